// File: doc/BRIEF.md
# Framebuffer Control Register File

This block is the register file of a palette-based framebuffer controller. A host reaches it through a simple request port carrying a 21-bit byte address, a write enable, an access size and 32-bit write data. Behind the port it holds:

- a constant identifier;
- a horizontal size and a vertical size, each kept in scaled units;
- a control word;
- a top-of-screen offset and a cursor position;
- three tables: a 256-entry colour lookup table, a 3-entry cursor colour table and a 512-entry cursor bitmap of 16-bit rows.

Byte and halfword writes never lose the other lanes. The block first reads the addressed word, merges the new lanes into it, and then commits the whole word.

The scan-out side reads the decoded pixel width, line count, colour depth, a blank flag and a cursor-enable flag directly as outputs. An invalidate pulse tells the scan-out side that what it has drawn is stale. A frame interrupt line is raised by a frame-done input and dropped by any register write. A write to a dedicated reset address returns the whole block to its power-up state.

Top module: `fbctl_regs`

## Requirements
- R1: A read of byte address 0x000000 returns ID_VALUE (default 0x10). A write to that address is accepted without error and changes nothing.
- R2: Writing N to 0x080118 makes `width` equal to 4·N, with N truncated to SIZE_W-2 bits. A read of 0x080118 returns N.
- R3: Writing N to 0x080150 makes `height` equal to N/2, rounded down. A read of 0x080150 returns 2·height.
- R4: The control word sits at 0x080300. `depth` is looked up from control bits [22:20]: codes 0..7 give 1, 2, 4, 8, 15, 16, 0, 0. `blank` equals control bit 10. `cursor_en` is the inverse of control bit 23. None of these outputs change without a write.
- R5: The colour lookup table spans 0x080800 up to 0x080800+8·PAL_ENTRIES, with entry index = (address−0x080800)>>3. Each entry stores write data bits [23:0], laid out as red [23:16], green [15:8], blue [7:0]. A read returns the entry zero-extended.
- R6: The cursor colour table has 3 entries starting at 0x080508, 8 bytes apart, each 24 bits. Address 0x080520 and above is not part of it.
- R7: The cursor bitmap spans 0x081000 up to 0x081000+8·PAT_ENTRIES, 8 bytes per entry. Each entry keeps write data bits [15:0]. A read returns the entry zero-extended.
- R8: `bus_size` selects the access width: 0 byte, 1 halfword, 2 or 3 word. A byte write takes its data from `bus_wdata[7:0]` and replaces lane `bus_addr[1:0]` of the current word. A halfword write takes `bus_wdata[15:0]` and replaces bits [31:16] when `bus_addr[1]` is 1, otherwise bits [15:0]. The other bits keep their current value.
- R9: The timing addresses are 0x080000, 0x080108, 0x080110, 0x080120, 0x080128, 0x080130, 0x080138, 0x080140, 0x080148, 0x080158, 0x080160, 0x080168, 0x080170 and 0x080200. Writes to them are accepted with no error and no effect. Reads of them return 0 with an error.
- R10: Any write to 0x180000 clears every table entry, the control word, the top offset, the cursor position, both sizes and `irq`.
- R11: `irq` rises the cycle after `frame_done` is high. It falls the cycle after any write. A write wins over a simultaneous `frame_done`.
- R12: An access to an unmapped address raises `acc_err` for one cycle, on the cycle after the request. A read of an unmapped address returns 0.
- R13: `inval` pulses for exactly one cycle after a write to any table, the control word, the top offset (0x080400) or the reset address. Writes to other addresses, including the cursor position, do not pulse it.
- R14: The top offset (0x080400) and the cursor position (0x080638) store and return all 32 bits. `rd_valid` and `rd_data` appear in the cycle after a read request, and a read issued after a write sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_addr | input | 21 | Byte address |
| bus_wdata | input | 32 | Write data (sub-word data right-aligned) |
| frame_done | input | 1 | End-of-frame event, raises the interrupt |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | One-cycle strobe for an invalid access |
| width | output | SIZE_W | Active width in pixels |
| height | output | SIZE_W | Active height in lines |
| depth | output | 5 | Bits per pixel decoded from the control word |
| blank | output | 1 | Force-blank flag |
| cursor_en | output | 1 | Hardware cursor enabled |
| inval | output | 1 | One-cycle invalidate pulse |
| irq | output | 1 | Frame interrupt |

## Verification
The bench builds the block with its default parameters: 256 colour entries, 512 bitmap rows, 12-bit sizes and identifier 0x10. With these values the last entry of each table sits exactly at the top of its address window, so the bench can probe both the final valid entry and the first address past the cursor colour table. The 12-bit size lets a maximal horizontal value of 1023 show the 4092-pixel result. Every depth code, each byte and halfword lane of the merge, and the write-over-frame-done race on the interrupt are exercised.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        RG_NONE, RG_ID, RG_IGN, RG_HDISP, RG_VDISP, RG_CTL,
        RG_TOP, RG_CPOS, RG_CPAL, RG_CLUT, RG_PAT, RG_RST
    } region_e;

    typedef struct packed {
        logic      req;
        logic      we;
        acc_size_e size;
        logic [1:0] lane;
        logic [31:0] data;
    } bus_cmd_t;

    localparam logic [20:0] A_ID    = 21'h000000;
    localparam logic [20:0] A_HDISP = 21'h080118;
    localparam logic [20:0] A_VDISP = 21'h080150;
    localparam logic [20:0] A_CTL   = 21'h080300;
    localparam logic [20:0] A_TOP   = 21'h080400;
    localparam logic [20:0] A_CPAL  = 21'h080508;
    localparam logic [20:0] A_CPOS  = 21'h080638;
    localparam logic [20:0] A_CLUT  = 21'h080800;
    localparam logic [20:0] A_PAT   = 21'h081000;
    localparam logic [20:0] A_RST   = 21'h180000;

    localparam int CTL_BLANK_BIT = 10;
    localparam int CTL_NOCUR_BIT = 23;
    localparam int CTL_DEPTH_LSB = 20;

    function automatic logic [4:0] depth_of(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd15;
            3'd5:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic is_timing(input logic [20:0] a);
        case (a)
            21'h080000, 21'h080108, 21'h080110, 21'h080120, 21'h080128,
            21'h080130, 21'h080138, 21'h080140, 21'h080148, 21'h080158,
            21'h080160, 21'h080168, 21'h080170, 21'h080200: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] merge_word(input logic [31:0] old,
                                               input logic [31:0] nw,
                                               input acc_size_e  size,
                                               input logic [1:0] lane);
        logic [31:0] res;
        res = old;
        case (size)
            SZ_BYTE: res[8*lane +: 8] = nw[7:0];
            SZ_HALF: begin
                if (lane[1]) res[31:16] = nw[15:0];
                else         res[15:0]  = nw[15:0];
            end
            default: res = nw;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
    import fbctl_pkg::*;
#(
    parameter int PAL_ENTRIES = 256,
    parameter int PAT_ENTRIES = 512,
    parameter int IDX_W       = 9
) (
    input  logic [18:0]      waddr,
    output region_e          region,
    output logic [IDX_W-1:0] idx
);
    localparam logic [20:0] CLUT_END = 21'(32'(A_CLUT) + PAL_ENTRIES * 8);
    localparam logic [20:0] PAT_END  = 21'(32'(A_PAT) + PAT_ENTRIES * 8);
    localparam logic [20:0] CPAL_END = A_CPAL + 21'd24;

    logic [20:0] wa;
    logic [20:0] off_clut, off_pat, off_cpal;

    assign wa       = {waddr, 2'b00};
    assign off_clut = wa - A_CLUT;
    assign off_pat  = wa - A_PAT;
    assign off_cpal = wa - A_CPAL;

    always_comb begin
        region = RG_NONE;
        idx    = '0;
        if (wa >= A_CLUT && wa < CLUT_END) begin
            region = RG_CLUT;
            idx    = IDX_W'(off_clut >> 3);
        end else if (wa >= A_PAT && wa < PAT_END) begin
            region = RG_PAT;
            idx    = IDX_W'(off_pat >> 3);
        end else if (wa >= A_CPAL && wa < CPAL_END) begin
            region = RG_CPAL;
            idx    = IDX_W'(off_cpal >> 3);
        end else begin
            case (wa)
                A_ID:    region = RG_ID;
                A_HDISP: region = RG_HDISP;
                A_VDISP: region = RG_VDISP;
                A_CTL:   region = RG_CTL;
                A_TOP:   region = RG_TOP;
                A_CPOS:  region = RG_CPOS;
                A_RST:   region = RG_RST;
                default: region = is_timing(wa) ? RG_IGN : RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/fbctl_table.sv
module fbctl_table #(
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 24,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [ENTRIES];
    logic in_rng;

    generate
        if ((1 << IDX_W) == ENTRIES) begin : g_full
            assign in_rng = 1'b1;
        end else begin : g_part
            assign in_rng = (32'(idx) < ENTRIES);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we && in_rng) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = in_rng ? mem[idx] : '0;
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
    import fbctl_pkg::*;
#(
    parameter int          PAL_ENTRIES = 256,
    parameter int          PAT_ENTRIES = 512,
    parameter int          SIZE_W      = 12,
    parameter logic [31:0] ID_VALUE    = 32'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [20:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              frame_done,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              acc_err,
    output logic [SIZE_W-1:0] width,
    output logic [SIZE_W-1:0] height,
    output logic [4:0]        depth,
    output logic              blank,
    output logic              cursor_en,
    output logic              inval,
    output logic              irq
);
    localparam int CLUT_IW = $clog2(PAL_ENTRIES);
    localparam int PAT_IW  = $clog2(PAT_ENTRIES);
    localparam int CPAL_IW = 2;
    localparam int IDX_W   = (CLUT_IW > PAT_IW) ? CLUT_IW : PAT_IW;

    bus_cmd_t          cmd;
    region_e           region;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       cur_word, new_word;
    logic              wr, rd, clr, rd_ok, wr_ok;

    logic [31:0]       ctl_q, top_q, cpos_q;
    logic [SIZE_W-3:0] hdisp_q;
    logic [SIZE_W-1:0] vres_q;
    logic [23:0]       clut_rd, cpal_rd;
    logic [15:0]       pat_rd;

    assign cmd = '{req: bus_req, we: bus_we, size: acc_size_e'(bus_size),
                   lane: bus_addr[1:0], data: bus_wdata};

    fbctl_decode #(.PAL_ENTRIES(PAL_ENTRIES), .PAT_ENTRIES(PAT_ENTRIES), .IDX_W(IDX_W))
    u_dec (.waddr(bus_addr[20:2]), .region(region), .idx(idx));

    assign wr  = cmd.req && cmd.we;
    assign rd  = cmd.req && !cmd.we;
    assign clr = wr && (region == RG_RST);

    always_comb begin
        case (region)
            RG_ID:    cur_word = ID_VALUE;
            RG_HDISP: cur_word = 32'(hdisp_q);
            RG_VDISP: cur_word = 32'({vres_q, 1'b0});
            RG_CTL:   cur_word = ctl_q;
            RG_TOP:   cur_word = top_q;
            RG_CPOS:  cur_word = cpos_q;
            RG_CPAL:  cur_word = {8'h00, cpal_rd};
            RG_CLUT:  cur_word = {8'h00, clut_rd};
            RG_PAT:   cur_word = {16'h0000, pat_rd};
            default:  cur_word = '0;
        endcase
    end

    assign rd_ok    = !(region inside {RG_NONE, RG_IGN, RG_RST});
    assign wr_ok    = (region != RG_NONE);
    assign new_word = merge_word(cur_word, cmd.data, cmd.size, cmd.lane);

    fbctl_table #(.ENTRIES(PAL_ENTRIES), .DATA_W(24), .IDX_W(CLUT_IW)) u_clut (
        .clk(clk), .rst(rst), .clr(clr), .we(wr && region == RG_CLUT),
        .idx(idx[CLUT_IW-1:0]), .wdata(new_word[23:0]), .rdata(clut_rd));

    fbctl_table #(.ENTRIES(3), .DATA_W(24), .IDX_W(CPAL_IW)) u_cpal (
        .clk(clk), .rst(rst), .clr(clr), .we(wr && region == RG_CPAL),
        .idx(idx[CPAL_IW-1:0]), .wdata(new_word[23:0]), .rdata(cpal_rd));

    fbctl_table #(.ENTRIES(PAT_ENTRIES), .DATA_W(16), .IDX_W(PAT_IW)) u_pat (
        .clk(clk), .rst(rst), .clr(clr), .we(wr && region == RG_PAT),
        .idx(idx[PAT_IW-1:0]), .wdata(new_word[15:0]), .rdata(pat_rd));

    // Scalar registers and interrupt; the reset address clears them like rst.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ctl_q   <= '0;
            top_q   <= '0;
            cpos_q  <= '0;
            hdisp_q <= '0;
            vres_q  <= '0;
            irq     <= 1'b0;
        end else begin
            if (wr) begin
                case (region)
                    RG_CTL:   ctl_q   <= new_word;
                    RG_TOP:   top_q   <= new_word;
                    RG_CPOS:  cpos_q  <= new_word;
                    RG_HDISP: hdisp_q <= new_word[SIZE_W-3:0];
                    RG_VDISP: vres_q  <= new_word[SIZE_W:1];
                    default:  ;
                endcase
            end
            if (wr)              irq <= 1'b0;
            else if (frame_done) irq <= 1'b1;
        end
    end

    // Response path: one registered cycle after the request.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            acc_err  <= 1'b0;
            inval    <= 1'b0;
        end else begin
            rd_valid <= rd;
            rd_data  <= (rd && rd_ok) ? cur_word : '0;
            acc_err  <= cmd.req && (cmd.we ? !wr_ok : !rd_ok);
            inval    <= wr && (region inside {RG_CLUT, RG_CPAL, RG_PAT, RG_TOP, RG_CTL, RG_RST});
        end
    end

    assign width     = {hdisp_q, 2'b00};
    assign height    = vres_q;
    assign depth     = depth_of(ctl_q[CTL_DEPTH_LSB +: 3]);
    assign blank     = ctl_q[CTL_BLANK_BIT];
    assign cursor_en = !ctl_q[CTL_NOCUR_BIT];
endmodule

// File: rtl/fbctl_chk.sv
module fbctl_chk #(
    parameter int          SIZE_W   = 12,
    parameter logic [31:0] ID_VALUE = 32'h10
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [20:0]       bus_addr,
    input logic              frame_done,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              acc_err,
    input logic [SIZE_W-1:0] width,
    input logic [SIZE_W-1:0] height,
    input logic [4:0]        depth,
    input logic              blank,
    input logic              cursor_en,
    input logic              inval,
    input logic              irq
);
    a_r14_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> rd_valid);

    a_r14_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_we) |=> !rd_valid);

    a_r1_id_value: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr[20:2] == 19'd0) |=> (rd_data == ID_VALUE && !acc_err));

    a_r4_depth_legal: assert property (@(posedge clk) disable iff (rst)
        (depth == 5'd0 || depth == 5'd1 || depth == 5'd2 || depth == 5'd4 ||
         depth == 5'd8 || depth == 5'd15 || depth == 5'd16));

    a_r4_blank_holds: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && bus_we) |=> $stable(blank) && $stable(cursor_en) && $stable(depth));

    a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr[20:2] == 19'h60000) |=>
        (width == '0 && height == '0 && !blank && cursor_en && !irq && inval));

    a_r11_write_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |=> !irq);

    a_r11_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(frame_done));

    a_r12_err_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && acc_err) |-> (rd_data == 32'h0));

    a_r13_inval_needs_write: assert property (@(posedge clk) disable iff (rst)
        inval |-> $past(bus_req && bus_we));
endmodule

bind fbctl_regs fbctl_chk #(.SIZE_W(SIZE_W), .ID_VALUE(ID_VALUE)) u_chk (.*);

// File: tb/sim_fbctl_regs.sv
module sim_fbctl_regs;
    localparam int SIZE_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]        bus_size = 2'd2;
    logic [20:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              frame_done = 1'b0;
    logic              rd_valid, acc_err, blank, cursor_en, inval, irq;
    logic [31:0]       rd_data;
    logic [SIZE_W-1:0] width, height;
    logic [4:0]        depth;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic        w_err, w_inval;
    logic [31:0] r_data;
    logic        r_err, r_valid;

    fbctl_regs u0 (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .frame_done(frame_done),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err), .width(width),
        .height(height), .depth(depth), .blank(blank), .cursor_en(cursor_en),
        .inval(inval), .irq(irq));

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        w_err = acc_err; w_inval = inval;
    endtask

    task automatic rd(input logic [20:0] a);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_size = 2'd2; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        r_data = rd_data; r_err = acc_err; r_valid = rd_valid;
    endtask

    task automatic t_reset;
        chk("R4 reset width", 32'(width), 0);
        chk("R4 reset height", 32'(height), 0);
        chk("R4 reset depth", 32'(depth), 1);
        chk("R4 reset blank/cursor", {30'd0, blank, cursor_en}, 32'd1);
        chk("R11 reset irq", 32'(irq), 0);
        rd(21'h080300);
        chk("R14 reset ctl read", r_data, 0);
        chk("R14 rd_valid", 32'(r_valid), 1);
    endtask

    task automatic t_id;
        rd(21'h000000);
        chk("R1 id read", r_data, 32'h10);
        wr(21'h000000, 2'd2, 32'hDEADBEEF);
        chk("R1 id write no err", 32'(w_err), 0);
        rd(21'h000000);
        chk("R1 id unchanged", r_data, 32'h10);
    endtask

    task automatic t_size;
        wr(21'h080118, 2'd2, 160);
        chk("R2 width 4N", 32'(width), 640);
        rd(21'h080118);
        chk("R2 hdisp readback", r_data, 160);
        wr(21'h080118, 2'd2, 1023);
        chk("R2 width max", 32'(width), 4092);
        wr(21'h080150, 2'd2, 961);
        chk("R3 height N/2", 32'(height), 480);
        rd(21'h080150);
        chk("R3 vdisp readback", r_data, 960);
    endtask

    task automatic t_ctl;
        logic [4:0] tbl [8] = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16, 5'd0, 5'd0};
        for (int c = 0; c < 8; c++) begin
            wr(21'h080300, 2'd2, 32'(c) << 20);
            chk($sformatf("R4 depth code %0d", c), 32'(depth), 32'(tbl[c]));
        end
        wr(21'h080300, 2'd2, 32'h0000_0400);
        chk("R4 blank set", {30'd0, blank, cursor_en}, 32'd3);
        wr(21'h080300, 2'd2, 32'h0080_0000);
        chk("R4 cursor off", {30'd0, blank, cursor_en}, 32'd0);
    endtask

    task automatic t_tables;
        wr(21'h080800, 2'd2, 32'hFF112233);
        wr(21'h080FF8, 2'd2, 32'h00ABCDEF);
        rd(21'h080800);
        chk("R5 clut entry 0", r_data, 32'h00112233);
        rd(21'h080FF8);
        chk("R5 clut last entry", r_data, 32'h00ABCDEF);
        for (int e = 0; e < 3; e++) wr(21'h080508 + 21'(8 * e), 2'd2, 32'h00100000 + 32'(e));
        for (int e = 0; e < 3; e++) begin
            rd(21'h080508 + 21'(8 * e));
            chk($sformatf("R6 cursor colour %0d", e), r_data, 32'h00100000 + 32'(e));
        end
        rd(21'h080520);
        chk("R6 past end err", {31'd0, r_err}, 1);
        chk("R6 past end data", r_data, 0);
        wr(21'h081FF8, 2'd2, 32'hABCD1234);
        rd(21'h081FF8);
        chk("R7 bitmap last row", r_data, 32'h00001234);
        rd(21'h081000);
        chk("R7 bitmap row 0", r_data, 0);
    endtask

    task automatic t_merge;
        wr(21'h080300, 2'd2, 32'h11223344);
        wr(21'h080302, 2'd0, 32'h000000AA);
        rd(21'h080300);
        chk("R8 byte lane 2", r_data, 32'h11AA3344);
        wr(21'h080302, 2'd1, 32'h0000BEEF);
        rd(21'h080300);
        chk("R8 half upper", r_data, 32'hBEEF3344);
        wr(21'h080300, 2'd1, 32'hFFFF5566);
        rd(21'h080300);
        chk("R8 half lower", r_data, 32'hBEEF5566);
        wr(21'h080303, 2'd0, 32'h00000001);
        wr(21'h080300, 2'd0, 32'h00000077);
        rd(21'h080300);
        chk("R8 byte lanes 3 and 0", r_data, 32'h01EF5577);
        wr(21'h080828, 2'd2, 32'h00102030);
        wr(21'h080829, 2'd0, 32'h000000FF);
        rd(21'h080828);
        chk("R8 clut byte merge", r_data, 32'h0010FF30);
        wr(21'h080300, 2'd3, 32'h00300000);
        chk("R8 size 3 full word depth", 32'(depth), 8);
    endtask

    task automatic t_timing;
        wr(21'h080108, 2'd2, 32'hFFFFFFFF);
        chk("R9 timing write no err", 32'(w_err), 0);
        chk("R9 timing write no inval", 32'(w_inval), 0);
        rd(21'h080300);
        chk("R9 ctl untouched", r_data, 32'h00300000);
        rd(21'h080200);
        chk("R9 timing read err", {31'd0, r_err}, 1);
        chk("R9 timing read zero", r_data, 0);
    endtask

    task automatic t_unmapped;
        rd(21'h040000);
        chk("R12 unmapped read err", {31'd0, r_err}, 1);
        chk("R12 unmapped read zero", r_data, 0);
        wr(21'h040000, 2'd2, 32'h1);
        chk("R12 unmapped write err", 32'(w_err), 1);
        @(negedge clk);
        chk("R12 err one cycle", 32'(acc_err), 0);
    endtask

    task automatic t_irq;
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        chk("R11 irq raised", 32'(irq), 1);
        wr(21'h080108, 2'd2, 0);
        chk("R11 write drops irq", 32'(irq), 0);
        @(negedge clk);
        frame_done = 1'b1; bus_req = 1'b1; bus_we = 1'b1; bus_addr = 21'h080638; bus_wdata = 0;
        @(negedge clk);
        frame_done = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        chk("R11 write beats frame_done", 32'(irq), 0);
    endtask

    task automatic t_inval_pos;
        wr(21'h080638, 2'd2, 32'h00A00123);
        chk("R13 cursor pos no inval", 32'(w_inval), 0);
        rd(21'h080638);
        chk("R14 cursor pos readback", r_data, 32'h00A00123);
        wr(21'h080400, 2'd2, 32'hCAFE0000);
        chk("R13 top inval", 32'(w_inval), 1);
        @(negedge clk);
        chk("R13 inval one cycle", 32'(inval), 0);
        rd(21'h080400);
        chk("R14 top readback", r_data, 32'hCAFE0000);
        wr(21'h081008, 2'd2, 32'h5);
        chk("R13 bitmap inval", 32'(w_inval), 1);
    endtask

    task automatic t_rstaddr;
        wr(21'h080300, 2'd2, 32'h00000400);
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        wr(21'h180000, 2'd2, 0);
        chk("R10 reset inval", 32'(w_inval), 1);
        chk("R10 reset err", 32'(w_err), 0);
        chk("R10 irq cleared", 32'(irq), 0);
        chk("R10 sizes cleared", {8'd0, width, height}, 0);
        chk("R10 blank cleared", 32'(blank), 0);
        rd(21'h080FF8);  chk("R10 clut cleared", r_data, 0);
        rd(21'h081FF8);  chk("R10 bitmap cleared", r_data, 0);
        rd(21'h080518);  chk("R10 cursor colour cleared", r_data, 0);
        rd(21'h080400);  chk("R10 top cleared", r_data, 0);
        rd(21'h080638);  chk("R10 cursor pos cleared", r_data, 0);
        rd(21'h080300);  chk("R10 ctl cleared", r_data, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_id();
        t_size();
        t_ctl();
        t_tables();
        t_merge();
        t_timing();
        t_unmapped();
        t_irq();
        t_inval_pos();
        t_rstaddr();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule